// File: doc/BRIEF.md
# Host Mailbox Register Block

This block sits on the peripheral side of a host link and gives the host and the local firmware a shared set of mailbox registers. The host reaches it over a simple synchronous register bus. The firmware uses single-cycle strobes. Two interrupt lines come out: one toward the host and one toward the firmware.

The host writes a command register. Each bit written as one produces a single-cycle pulse to the firmware, which raises the peripheral interrupt for that cycle. There are three commands: open the data path, close it, and reset the transfer queues. The firmware reports to the host through a status register. When the firmware posts an outgoing packet, a data-pending bit is set and the packet length is added to a cumulative byte counter. Posting then stays blocked until the host acknowledges the packet by clearing that bit. A second cumulative counter totals the receive buffers the firmware has granted.

The host works out per-packet lengths and free buffers from differences between successive readings of these counters. A read-only word reports the feature set.

Top module: `hmbx_regs`

## Requirements
- R1: After reset, every register reads zero except the capability word, and `h_irq`, `p_irq`, `p_busy` and `p_cmd` are low.
- R2: A host write to word address 0 produces, in the cycle after the write, a one-cycle pulse on `p_cmd` equal to data bits [2:0] (bit 0 open, bit 1 close, bit 2 queue reset), with `p_irq` high in that cycle. Address 0 always reads zero.
- R3: An accepted post (`p_post` high while status bit 23 is clear) adds `p_len` to the transmit byte counter (address 3), modulo 2^32, and sets status bit 23. Bit 23 is the data-pending flag, mirrored on `p_busy`.
- R4: A post made while status bit 23 is set is ignored, and the transmit byte counter does not change.
- R5: A host write to the status register (address 1) clears exactly those bits written as one. Bits written as zero keep their value.
- R6: A `p_grant` strobe adds `p_grant_cnt` to the receive buffer counter (address 4), modulo 2^32.
- R7: `h_irq` is high exactly when some status bit is set and its bit in the enable register (address 2, read/write) is also set.
- R8: A queue reset pulse clears both counters and the whole status register on the following clock edge. It takes priority over a post or a grant in that same cycle.
- R9: The capability word at address 5 reads the parameter `CAPS` (bit 0 wireless LAN, bit 1 Bluetooth over UART, bit 2 Bluetooth over the host link, bit 3 low-energy only, bit 4 classic only). Host writes to it have no effect.
- R10: Word addresses 6 and 7 read zero.
- R11: `p_sts_set` sets status bits other than bit 23. When a firmware set and a host clear hit the same bit in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| h_sel | input | 1 | Host bus access this cycle |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 3 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid in the cycle of a read access |
| h_irq | output | 1 | Interrupt to host |
| p_post | input | 1 | Firmware posts an outgoing packet |
| p_len | input | 32 | Byte length of the posted packet |
| p_busy | output | 1 | Packet pending, further posts ignored |
| p_grant | input | 1 | Firmware grants receive buffers |
| p_grant_cnt | input | 8 | Number of buffers granted |
| p_sts_set | input | 32 | Firmware status bit set strobes |
| p_cmd | output | 3 | Command pulses: open, close, queue reset |
| p_irq | output | 1 | Interrupt to firmware |

## Verification
The assertions check several rules on every cycle. A command pulse must always trace back to a host write of the command address. The command address must always read zero. A post accepted while idle must set the pending flag. The byte counter must never move while a packet is pending. A queue reset pulse must leave both counters and the status register at zero. The host interrupt must only rise with a nonzero status and must stay low with nothing enabled. The bench scenarios cover what needs specific data: counter sums and wraparound, the set-wins-over-clear collision, a post racing a queue reset, the write-immune capability word and the unmapped addresses.

// File: rtl/hmbx_pkg.sv
// Shared address map and bit positions for the host mailbox block.
// Assumes word addressing on the host bus.
package hmbx_pkg;
    localparam int HB_AW = 3;
    localparam int NCMD  = 3;
    localparam int CMD_OPEN  = 0;
    localparam int CMD_CLOSE = 1;
    localparam int CMD_QRST  = 2;
    localparam int STS_DATA  = 23;

    typedef enum logic [HB_AW-1:0] {
        RG_CMD   = 3'd0,
        RG_STS   = 3'd1,
        RG_EN    = 3'd2,
        RG_TXLEN = 3'd3,
        RG_RXBUF = 3'd4,
        RG_CAPS  = 3'd5
    } reg_e;
endpackage

// File: rtl/hmbx_cmd.sv
// Command pulse generator. A host write to the command word launches a
// one-cycle pulse per bit written as one. Assumes writes are single-cycle strobes.
module hmbx_cmd #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] pulse
);
    // Hold the command bits for exactly one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n)      pulse <= '0;
        else if (wr_stb) pulse <= wr_bits;
        else             pulse <= '0;
    end
endmodule

// File: rtl/hmbx_accum.sv
// Cumulative credit counter. Adds a zero-extended increment on each strobe
// and wraps modulo 2^W. A clear request takes priority over an add.
module hmbx_accum #(
    parameter int W    = 32,
    parameter int IN_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            add_en,
    input  logic [IN_W-1:0] add_val,
    output logic [W-1:0]    total
);
    localparam int PADW = (W > IN_W) ? (W - IN_W) : 0;

    logic [W-1:0] inc;

    // Extend or trim the increment to the counter width.
    generate
        if (PADW > 0) begin : g_pad
            assign inc = {{PADW{1'b0}}, add_val};
        end else begin : g_trim
            assign inc = add_val[W-1:0];
        end
    endgenerate

    // Accumulate; clear wins over add.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) total <= '0;
        else if (add_en)   total <= total + inc;
    end
endmodule

// File: rtl/hmbx_status.sv
// Host interrupt status and enable registers. Bits are set by firmware or by
// the hardware data-pending event and cleared by host write-one-to-clear.
// A set beats a clear in the same cycle; a clear-all beats everything.
module hmbx_status #(
    parameter int W      = 32,
    parameter int HW_BIT = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         hw_set,
    input  logic [W-1:0] fw_set,
    input  logic         w1c_stb,
    input  logic [W-1:0] w1c_bits,
    input  logic         en_stb,
    input  logic [W-1:0] en_bits,
    output logic [W-1:0] sts,
    output logic [W-1:0] en,
    output logic         irq
);
    logic [W-1:0] hw_mask;
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    // Build the set and clear vectors; firmware may not touch the hardware bit.
    always_comb begin
        hw_mask         = '0;
        hw_mask[HW_BIT] = 1'b1;
        set_v           = (fw_set & ~hw_mask) | (hw_set ? hw_mask : '0);
        clr_v           = w1c_stb ? w1c_bits : '0;
    end

    // Update the status bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) sts <= '0;
        else                   sts <= (sts & ~clr_v) | set_v;
    end

    // Host-owned enable register, reset only by the block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      en <= '0;
        else if (en_stb) en <= en_bits;
    end

    assign irq = |(sts & en);
endmodule

// File: rtl/hmbx_regs.sv
// Top of the host mailbox register block. Decodes the host bus, routes the
// firmware strobes and muxes read data. Assumes one clock for both sides and
// single-cycle bus accesses; read data is combinational in the access cycle.
module hmbx_regs
    import hmbx_pkg::*;
#(
    parameter int          DW    = 32,
    parameter int          LEN_W = 32,
    parameter int          GNT_W = 8,
    parameter logic [4:0]  CAPS  = 5'b00101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_sel,
    input  logic             h_wr,
    input  logic [HB_AW-1:0] h_addr,
    input  logic [DW-1:0]    h_wdata,
    output logic [DW-1:0]    h_rdata,
    output logic             h_irq,
    input  logic             p_post,
    input  logic [LEN_W-1:0] p_len,
    output logic             p_busy,
    input  logic             p_grant,
    input  logic [GNT_W-1:0] p_grant_cnt,
    input  logic [DW-1:0]    p_sts_set,
    output logic [NCMD-1:0]  p_cmd,
    output logic             p_irq
);
    localparam int CAPW = 5;

    logic          wr_cmd, wr_sts, wr_en, rd_acc;
    logic          qrst;
    logic          post_ok;
    logic [DW-1:0] tx_len_q;
    logic [DW-1:0] rx_buf_q;
    logic [DW-1:0] sts_q;
    logic [DW-1:0] en_q;
    logic [DW-1:0] caps_w;

    // Write strobes per register.
    always_comb begin
        wr_cmd = h_sel && h_wr && (h_addr == RG_CMD);
        wr_sts = h_sel && h_wr && (h_addr == RG_STS);
        wr_en  = h_sel && h_wr && (h_addr == RG_EN);
        rd_acc = h_sel && !h_wr;
    end

    assign caps_w  = {{(DW-CAPW){1'b0}}, CAPS};
    assign qrst    = p_cmd[CMD_QRST];
    assign p_busy  = sts_q[STS_DATA];
    assign post_ok = p_post && !p_busy;
    assign p_irq   = |p_cmd;

    hmbx_cmd #(.N(NCMD)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_cmd),
        .wr_bits (h_wdata[NCMD-1:0]),
        .pulse   (p_cmd)
    );

    hmbx_accum #(.W(DW), .IN_W(LEN_W)) u_txlen (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (qrst),
        .add_en  (post_ok),
        .add_val (p_len),
        .total   (tx_len_q)
    );

    hmbx_accum #(.W(DW), .IN_W(GNT_W)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (qrst),
        .add_en  (p_grant),
        .add_val (p_grant_cnt),
        .total   (rx_buf_q)
    );

    hmbx_status #(.W(DW), .HW_BIT(STS_DATA)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (qrst),
        .hw_set   (post_ok),
        .fw_set   (p_sts_set),
        .w1c_stb  (wr_sts),
        .w1c_bits (h_wdata),
        .en_stb   (wr_en),
        .en_bits  (h_wdata),
        .sts      (sts_q),
        .en       (en_q),
        .irq      (h_irq)
    );

    // Read mux; command word and unmapped addresses return zero.
    always_comb begin
        h_rdata = '0;
        if (rd_acc) begin
            case (h_addr)
                RG_STS:   h_rdata = sts_q;
                RG_EN:    h_rdata = en_q;
                RG_TXLEN: h_rdata = tx_len_q;
                RG_RXBUF: h_rdata = rx_buf_q;
                RG_CAPS:  h_rdata = caps_w;
                default:  h_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hmbx_regs_chk.sv
// Property checker for the host mailbox block, attached by bind.
module hmbx_regs_chk
    import hmbx_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             h_sel,
    input logic             h_wr,
    input logic [HB_AW-1:0] h_addr,
    input logic [DW-1:0]    h_rdata,
    input logic             h_irq,
    input logic             p_post,
    input logic             p_busy,
    input logic [NCMD-1:0]  p_cmd,
    input logic [DW-1:0]    tx_len,
    input logic [DW-1:0]    rx_buf,
    input logic [DW-1:0]    sts,
    input logic [DW-1:0]    en
);
    a_r2_cmd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (p_cmd != '0) |-> $past(h_sel && h_wr && h_addr == RG_CMD));

    a_r2_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sel && !h_wr && h_addr == RG_CMD) |-> (h_rdata == '0));

    a_r3_post_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (p_post && !p_busy && !p_cmd[CMD_QRST]) |=> p_busy);

    a_r4_no_count_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (p_busy && !p_cmd[CMD_QRST]) |=> $stable(tx_len));

    a_r8_qrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        p_cmd[CMD_QRST] |=> (tx_len == '0 && rx_buf == '0 && sts == '0));

    a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        h_irq |-> (sts != '0));

    a_r7_irq_quiet_unenabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !h_irq);
endmodule

bind hmbx_regs hmbx_regs_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_sel   (h_sel),
    .h_wr    (h_wr),
    .h_addr  (h_addr),
    .h_rdata (h_rdata),
    .h_irq   (h_irq),
    .p_post  (p_post),
    .p_busy  (p_busy),
    .p_cmd   (p_cmd),
    .tx_len  (tx_len_q),
    .rx_buf  (rx_buf_q),
    .sts     (sts_q),
    .en      (en_q)
);

// File: tb/sim_hmbx_regs.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module sim_hmbx_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_sel = 1'b0, h_wr = 1'b0;
    logic [2:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_irq, p_busy, p_irq;
    logic        p_post = 1'b0, p_grant = 1'b0;
    logic [31:0] p_len = '0;
    logic [7:0]  p_grant_cnt = '0;
    logic [31:0] p_sts_set = '0;
    logic [2:0]  p_cmd;

    int nchk = 0, nerr = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        rd_ev;

    always #4 clk = ~clk;

    hmbx_regs u0 (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .p_post(p_post),
        .p_len(p_len), .p_busy(p_busy), .p_grant(p_grant), .p_grant_cnt(p_grant_cnt),
        .p_sts_set(p_sts_set), .p_cmd(p_cmd), .p_irq(p_irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected word and compare against the bus.
    always begin
        @(rd_ev);
        check(tag_q.pop_front(), h_rdata, exp_q.pop_front());
    end

    task automatic host_rd(logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b0; h_addr = a;
        #2;
        exp_q.push_back(exp); tag_q.push_back(tag);
        -> rd_ev;
        @(negedge clk);
        h_sel = 1'b0;
    endtask

    task automatic host_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0;
    endtask

    task automatic post(logic [31:0] len);
        @(negedge clk);
        p_post = 1'b1; p_len = len;
        @(negedge clk);
        p_post = 1'b0;
    endtask

    task automatic grant(logic [7:0] n);
        @(negedge clk);
        p_grant = 1'b1; p_grant_cnt = n;
        @(negedge clk);
        p_grant = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 h_irq", {31'b0, h_irq}, 0);
        check("R1 p_irq", {31'b0, p_irq}, 0);
        check("R1 p_busy", {31'b0, p_busy}, 0);
        check("R1 p_cmd", {29'b0, p_cmd}, 0);
        host_rd(3'd1, 0, "R1 status");
        host_rd(3'd2, 0, "R1 enable");
        host_rd(3'd3, 0, "R1 txlen");
        host_rd(3'd4, 0, "R1 rxbuf");
        host_rd(3'd5, 32'h5, "R9 caps reset");
        // R2 command pulses
        host_wr(3'd0, 32'h1);
        check("R2 open pulse", {29'b0, p_cmd}, 3'b001);
        check("R2 p_irq", {31'b0, p_irq}, 1);
        @(negedge clk);
        check("R2 pulse ends", {29'b0, p_cmd}, 0);
        host_wr(3'd0, 32'h2);
        check("R2 close pulse", {29'b0, p_cmd}, 3'b010);
        host_rd(3'd0, 0, "R2 cmd reads zero");
        // R6 grants
        grant(8'd3);
        grant(8'd5);
        host_rd(3'd4, 32'd8, "R6 rxbuf sum");
        // R3 post
        post(32'h40);
        check("R3 busy", {31'b0, p_busy}, 1);
        host_rd(3'd3, 32'h40, "R3 txlen");
        host_rd(3'd1, 32'h0080_0000, "R3 status bit23");
        // R4 blocked post
        post(32'h10);
        host_rd(3'd3, 32'h40, "R4 txlen unchanged");
        // R7 enable gating
        check("R7 irq masked", {31'b0, h_irq}, 0);
        host_wr(3'd2, 32'h0080_0000);
        check("R7 irq enabled", {31'b0, h_irq}, 1);
        host_rd(3'd2, 32'h0080_0000, "R7 enable readback");
        // R5 W1C
        host_wr(3'd1, 32'h0);
        host_rd(3'd1, 32'h0080_0000, "R5 zero write keeps");
        host_wr(3'd1, 32'h0080_0000);
        check("R5 busy cleared", {31'b0, p_busy}, 0);
        check("R5 irq cleared", {31'b0, h_irq}, 0);
        post(32'h20);
        host_rd(3'd3, 32'h60, "R3 second post");
        // R11 firmware set beats host clear
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = 3'd1; h_wdata = 32'h8; p_sts_set = 32'h8;
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0; p_sts_set = '0;
        host_rd(3'd1, 32'h0080_0008, "R11 set wins");
        // R8 queue reset racing a post (clear busy first so the post is eligible)
        host_wr(3'd1, 32'h0080_0000);
        host_wr(3'd0, 32'h4);
        check("R8 qrst pulse", {29'b0, p_cmd}, 3'b100);
        p_post = 1'b1; p_len = 32'h99; p_grant = 1'b1; p_grant_cnt = 8'd2;
        @(negedge clk);
        p_post = 1'b0; p_grant = 1'b0;
        host_rd(3'd3, 0, "R8 txlen cleared");
        host_rd(3'd4, 0, "R8 rxbuf cleared");
        host_rd(3'd1, 0, "R8 status cleared");
        check("R8 busy low", {31'b0, p_busy}, 0);
        // R3 wraparound
        post(32'h10);
        host_wr(3'd1, 32'h0080_0000);
        post(32'hFFFF_FFF8);
        host_rd(3'd3, 32'h8, "R3 wrap");
        // R9 caps immune, R10 unmapped
        host_wr(3'd5, 32'hFFFF_FFFF);
        host_rd(3'd5, 32'h5, "R9 caps write ignored");
        host_rd(3'd6, 0, "R10 addr6");
        host_rd(3'd7, 0, "R10 addr7");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule